// File: doc/BRIEF.md
# Fan PWM Generator with Two-Stage Prescaler

This block drives a single fan-control pulse-width-modulated output from the system clock. A prescaler built from two cascaded stages turns the clock into a slow tick. The first stage divides by a power of two, and the second divides by one or by an even number. A period counter advances on that tick. Two compare points, rise and fall, place the high phase of the output inside each period.

Three timing profiles, with indices 0, 1 and 2, are presented side by side at the ports. Each profile carries its own divider codes and its own period length, and a 2-bit selector picks the profile the generator follows. The generator copies all timing inputs into shadow registers only at a period boundary, so a change made in mid-period never shortens or stretches the pulse already in progress. While the generator is disabled, the shadows follow the inputs on every cycle, and the next enable starts a fresh period with the current settings.

Top module: `fan_pwm_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pwm_o` is low.
- R2: The power-of-two stage divides the clock by 2^h, where h is the 4-bit high divider code of the active profile (h = 0 gives division by 1).
- R3: The linear stage divides by 1 when its 4-bit low code L is zero, and by 2*L otherwise, so one prescaled tick spans D = 2^h * (L==0 ? 1 : 2L) clock cycles.
- R4: One PWM period lasts P+1 prescaled ticks, where P is the 8-bit period value of the active profile. The counter value c runs 0..P and then wraps to 0.
- R5: With fall point F nonzero, `pwm_o` is high exactly while the counter value c satisfies rise <= c < F. It is registered, so it shows the level for counter state c one clock later.
- R6: A fall point of 0 means that the output never falls inside the period: it is high from the rise point to the end of the period, so rise = 0 with fall = 0 gives full duty.
- R7: When `enable_i` is low, `pwm_o` is low from the next clock edge onward and both counters are held at zero. The first cycle after a new enable begins with counter value 0.
- R8: `type_sel_i` values 0, 1 and 2 select profile k, whose fields are `prof_hi_i[4k+3:4k]`, `prof_lo_i[4k+3:4k]` and `prof_per_i[8k+7:8k]`. The value 3 selects profile 0.
- R9: While the generator is enabled, changes to the rise point, fall point, selector and profile fields take effect only after the counter wraps from P to 0. The period in progress completes with the old values.
- R10: A rise point greater than P keeps `pwm_o` low for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Run enable; low holds the output inactive |
| type_sel_i | input | 2 | Profile selector (3 aliases profile 0) |
| prof_hi_i | input | 12 | Power-of-two divider codes, 4 bits per profile |
| prof_lo_i | input | 12 | Linear divider codes, 4 bits per profile |
| prof_per_i | input | 24 | Period values, 8 bits per profile |
| rise_i | input | 8 | Counter value at which the output rises |
| fall_i | input | 8 | Counter value at which the output falls (0 = no fall) |
| pwm_o | output | 1 | Fan PWM output |

## Verification
A fault in either prescaler counter shows at the port within one period as a high or low phase whose length is not a multiple of D. A fault in the period counter or the compare logic shows as a high-phase width or position that differs from the arithmetic model, which is visible in the first period after enable. A shadow register that loads at the wrong time appears as a pulse in the current period that takes on new rise, fall or period values, visible within D*(P+1) cycles of the input change. The sweeps therefore compare every cycle over two full periods for each configuration, and they cover mid-period updates, reserved selector values, and disable followed by restart.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
    localparam int unsigned HI_W   = 4;
    localparam int unsigned LO_W   = 4;
    localparam int unsigned PER_W  = 8;
    localparam int unsigned SEL_W  = 2;
    // widest power-of-two stage count: 2^(2^HI_W - 1) - 1
    localparam int unsigned HCNT_W = (1 << HI_W) - 1;
    localparam int unsigned LDIV_W = LO_W + 1;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
        logic [PER_W-1:0] per;
    } prof_t;

    typedef struct packed {
        prof_t            prof;
        logic [PER_W-1:0] rise;
        logic [PER_W-1:0] fall;
    } shadow_t;

    // linear stage ratio: 1 for a zero code, otherwise twice the code
    function automatic logic [LDIV_W-1:0] lo_div_of(input logic [LO_W-1:0] code);
        return (code == '0) ? LDIV_W'(1) : {code, 1'b0};
    endfunction
endpackage

// File: rtl/fpwm_prof_mux.sv
module fpwm_prof_mux
    import fpwm_pkg::*;
#(
    parameter int unsigned N_PROF = 3
) (
    input  prof_t [N_PROF-1:0] profs_i,
    input  logic  [SEL_W-1:0]  sel_i,
    output prof_t              prof_o
);
    // selector values past the last profile fall back to profile 0
    always_comb begin
        prof_o = profs_i[0];
        for (int i = 1; i < N_PROF; i++) begin
            if (sel_i == SEL_W'(i)) prof_o = profs_i[i];
        end
    end
endmodule

// File: rtl/fpwm_prescale.sv
module fpwm_prescale
    import fpwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [HI_W-1:0] hi_code_i,
    input  logic [LO_W-1:0] lo_code_i,
    output logic            tick_o
);
    localparam int unsigned HT_W = HCNT_W + 1;

    typedef struct packed {
        logic [HCNT_W-1:0] hcnt;
        logic [LDIV_W-1:0] lcnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    logic [HT_W-1:0]   hspan;
    logic [HCNT_W-1:0] hmax;
    logic [LDIV_W-1:0] lmax;
    logic              hwrap;

    always_comb begin
        hspan  = HT_W'(1) << hi_code_i;
        hmax   = HCNT_W'(hspan - HT_W'(1));
        lmax   = lo_div_of(lo_code_i) - LDIV_W'(1);
        hwrap  = (st_q.hcnt == hmax);
        tick_o = run_i && hwrap && (st_q.lcnt == lmax);

        st_d = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (hwrap) begin
            st_d.hcnt = '0;
            st_d.lcnt = (st_q.lcnt == lmax) ? '0 : st_q.lcnt + LDIV_W'(1);
        end else begin
            st_d.hcnt = st_q.hcnt + HCNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: power-of-two stage never passes its terminal count
    a_r2_hcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hcnt <= hmax);
    // R3: linear stage never passes its terminal count
    a_r3_lcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lcnt <= lmax);
    // R7: stopped prescaler is cleared on the next edge
    a_r7_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.hcnt == '0 && st_q.lcnt == '0));
endmodule

// File: rtl/fpwm_period.sv
module fpwm_period
    import fpwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en_i,
    input  logic    tick_i,
    input  shadow_t live_i,
    output shadow_t shd_o,
    output logic    pwm_o
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        shadow_t          shd;
        logic             pwm;
    } per_st_t;

    per_st_t st_d, st_q;

    logic             wrap;
    logic [PER_W:0]   fall_eff;
    logic             level;

    always_comb begin
        wrap     = tick_i && (st_q.cnt == st_q.shd.prof.per);
        // a zero fall point moves the fall past the last count
        fall_eff = (st_q.shd.fall == '0) ? ({1'b0, st_q.shd.prof.per} + (PER_W+1)'(1))
                                         : {1'b0, st_q.shd.fall};
        level    = (st_q.cnt >= st_q.shd.rise) && ({1'b0, st_q.cnt} < fall_eff);

        st_d = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
            st_d.shd = live_i;
            st_d.pwm = 1'b0;
        end else begin
            if (tick_i) st_d.cnt = wrap ? '0 : st_q.cnt + PER_W'(1);
            if (wrap)   st_d.shd = live_i;
            st_d.pwm = level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shd_o = st_q.shd;
    assign pwm_o = st_q.pwm;

    // R4: period counter stays inside 0..P
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.shd.prof.per);
    // R9: shadows hold while running between boundaries
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !wrap) |=> $stable(st_q.shd));
    // R6: rise 0 with fall 0 drives the output high
    a_r6_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.shd.rise == '0 && st_q.shd.fall == '0) |=> st_q.pwm);
    // R7: disabled generator drives low on the next edge
    a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.pwm);
    // R10: rise point beyond the period keeps the output low
    a_r10_late_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.shd.rise > st_q.shd.prof.per) |=> !st_q.pwm);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
    import fpwm_pkg::*;
#(
    parameter int unsigned N_PROF = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable_i,
    input  logic [SEL_W-1:0]          type_sel_i,
    input  logic [N_PROF*HI_W-1:0]    prof_hi_i,
    input  logic [N_PROF*LO_W-1:0]    prof_lo_i,
    input  logic [N_PROF*PER_W-1:0]   prof_per_i,
    input  logic [PER_W-1:0]          rise_i,
    input  logic [PER_W-1:0]          fall_i,
    output logic                      pwm_o
);
    prof_t [N_PROF-1:0] profs;
    prof_t              sel_prof;
    shadow_t            live;
    shadow_t            shd;
    logic               tick;

    for (genvar g = 0; g < N_PROF; g++) begin : g_prof
        assign profs[g].hi  = prof_hi_i[g*HI_W +: HI_W];
        assign profs[g].lo  = prof_lo_i[g*LO_W +: LO_W];
        assign profs[g].per = prof_per_i[g*PER_W +: PER_W];
    end

    fpwm_prof_mux #(.N_PROF(N_PROF)) u_mux (
        .profs_i (profs),
        .sel_i   (type_sel_i),
        .prof_o  (sel_prof)
    );

    assign live.prof = sel_prof;
    assign live.rise = rise_i;
    assign live.fall = fall_i;

    fpwm_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (enable_i),
        .hi_code_i (shd.prof.hi),
        .lo_code_i (shd.prof.lo),
        .tick_o    (tick)
    );

    fpwm_period u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable_i),
        .tick_i (tick),
        .live_i (live),
        .shd_o  (shd),
        .pwm_o  (pwm_o)
    );
endmodule

// File: tb/fan_pwm_gen_tb.sv
`timescale 1ns/1ps
module fan_pwm_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic [1:0]  type_sel_i = '0;
    logic [11:0] prof_hi_i = '0;
    logic [11:0] prof_lo_i = '0;
    logic [23:0] prof_per_i = '0;
    logic [7:0]  rise_i = '0;
    logic [7:0]  fall_i = '0;
    logic        pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fan_pwm_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .type_sel_i(type_sel_i),
        .prof_hi_i(prof_hi_i), .prof_lo_i(prof_lo_i), .prof_per_i(prof_per_i),
        .rise_i(rise_i), .fall_i(fall_i), .pwm_o(pwm_o)
    );

    function automatic int div_of(int hi, int lo);
        return (1 << hi) * ((lo == 0) ? 1 : 2 * lo);
    endfunction

    function automatic bit exp_level(int k, int p, int d, int r, int f);
        int c = (k / d) % (p + 1);
        int fe = (f == 0) ? p + 1 : f;
        return (c >= r) && (c < fe);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check1(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
        end
    endtask

    task automatic set_prof(int slot, int hi, int lo, int per);
        prof_hi_i[slot*4 +: 4]  = 4'(hi);
        prof_lo_i[slot*4 +: 4]  = 4'(lo);
        prof_per_i[slot*8 +: 8] = 8'(per);
    endtask

    task automatic fill_junk();
        for (int s = 0; s < 3; s++) set_prof(s, 1, 3, 4);
    endtask

    // samples k in [k0,k1) against the model shifted by base
    task automatic run_win(string req, int k0, int k1, int base,
                           int p, int d, int r, int f);
        int bad = 0;
        logic fa = 0, fe = 0;
        for (int k = k0; k < k1; k++) begin
            bit e;
            step();
            e = exp_level(k - base, p, d, r, f);
            if (pwm_o !== e && bad == 0) begin fa = pwm_o; fe = e; end
            if (pwm_o !== e) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s p=%0d d=%0d r=%0d f=%0d actual=%0b expected=%0b (%0d bad)",
                     req, p, d, r, f, fa, fe, bad);
        end
    endtask

    task automatic configure(int slot, int hi, int lo, int per, int r, int f, int sel);
        enable_i = 0;
        fill_junk();
        set_prof(slot, hi, lo, per);
        type_sel_i = 2'(sel);
        rise_i = 8'(r);
        fall_i = 8'(f);
        step();
        step();
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pers[3] = '{0, 2, 5};
        int rs[5]   = '{0, 1, 0, 2, 6};
        int fs[5]   = '{0, 3, 1, 0, 7};
        int idx = 0;

        // R1: output low in reset and just after
        repeat (3) step();
        check1("R1 in reset", pwm_o, 1'b0);
        rst_n = 1;
        step();
        check1("R1 after reset", pwm_o, 1'b0);

        // main sweep: R5, R6, R10, plus profile slots (R8)
        for (int hi = 0; hi < 3; hi++)
            for (int lo = 0; lo < 4; lo++)
                for (int pi = 0; pi < 3; pi++)
                    for (int ci = 0; ci < 5; ci++) begin
                        int p = pers[pi];
                        int d = div_of(hi, lo);
                        int slot = idx % 3;
                        string tag;
                        idx++;
                        configure(slot, hi, lo, p, rs[ci], fs[ci], slot);
                        check1("R7 idle low", pwm_o, 1'b0);
                        if (rs[ci] > p)        tag = "R10 sweep";
                        else if (fs[ci] == 0)  tag = "R6 sweep";
                        else                   tag = "R5 sweep";
                        enable_i = 1;
                        run_win(tag, 0, 2 * d * (p + 1), 0, p, d, rs[ci], fs[ci]);
                    end

        // R2: hi=3 gives 8-cycle ticks
        configure(0, 3, 0, 1, 0, 1, 0);
        enable_i = 1;
        run_win("R2 pow2 stage", 0, 64, 0, 1, 8, 0, 1);

        // R3: lo=5 gives 10-cycle ticks
        configure(1, 0, 5, 2, 1, 2, 1);
        enable_i = 1;
        run_win("R3 linear stage", 0, 90, 0, 2, 10, 1, 2);

        // R4: period of 10 ticks at full clock
        configure(2, 0, 0, 9, 3, 7, 2);
        enable_i = 1;
        run_win("R4 period length", 0, 40, 0, 9, 1, 3, 7);

        // R8: selector 3 aliases profile 0
        configure(0, 1, 1, 3, 1, 3, 3);
        enable_i = 1;
        run_win("R8 sel3 to profile0", 0, 32, 0, 3, 4, 1, 3);

        // R7: disable mid-run, stays low, restarts at count 0
        configure(1, 0, 1, 5, 0, 4, 1);
        enable_i = 1;
        run_win("R7 before stop", 0, 7, 0, 5, 2, 0, 4);
        enable_i = 0;
        step();
        check1("R7 low next edge", pwm_o, 1'b0);
        step();
        step();
        check1("R7 held low", pwm_o, 1'b0);
        enable_i = 1;
        run_win("R7 restart from zero", 0, 24, 0, 5, 2, 0, 4);

        // R9: mid-period change deferred to the boundary (at k=8)
        configure(0, 0, 1, 3, 1, 3, 0);
        enable_i = 1;
        run_win("R9 old values", 0, 3, 0, 3, 2, 1, 3);
        set_prof(0, 0, 2, 2);
        rise_i = 0;
        fall_i = 2;
        run_win("R9 old period completes", 3, 8, 0, 3, 2, 1, 3);
        run_win("R9 new values at boundary", 8, 32, 8, 2, 4, 0, 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule